// File: doc/BRIEF.md
# Floating-point round-and-pack unit

This block takes an unpacked double-precision value and produces the packed 64-bit word and its exception flags. The value arrives as a sign, a signed exponent and a 64-bit significand. The significand's bit 63 is carry headroom and must be zero. Bit 62 is the hidden integer bit. Bits 61..10 form the fraction, and bits 9..0 are rounding bits that lie below the result's least significant bit.

The exponent input is one less than the biased exponent of the packed result when the hidden bit is set. Packing therefore adds the exponent, shifted to the field position, to the rounded significand with its hidden bit still present. A carry out of rounding raises the exponent field by itself.

A 3-bit mode picks one of six rounding rules. Five of them follow IEEE 754. The sixth is a round-to-odd rule, used where a wide intermediate will be rounded a second time. In round-to-odd, any inexact result is forced onto the neighbour whose last bit is 1, and overflow saturates to the largest finite value. Results with a negative exponent are tiny. They are shifted into the subnormal range with a sticky bit, or flushed to a signed zero when flush-to-zero is on. Inputs are captured with a valid strobe, and the outputs are registered one clock later.

Top module: `fprp_round_pack`

## Requirements
- R1: While synchronous reset is high, out_valid, out_word and all three flags are 0 after the next clock edge.
- R2: out_valid equals in_valid of the previous cycle. A valid input carries only mode codes 0 to 5; codes 6 and 7 are illegal.
- R3: Mode 0 rounds to nearest with ties to the even neighbour. Mode 4 rounds to nearest with ties away from zero.
- R4: Mode 1 rounds toward minus infinity, mode 2 rounds toward plus infinity, and mode 3 truncates toward zero.
- R5: Mode 5 leaves an exact value unchanged. For an inexact value it selects whichever of the two neighbouring representable values has result bit 0 equal to 1.
- R6: Overflow occurs when the exponent is at least 0x7FD and either the exponent exceeds 0x7FD or rounding carries the significand into bit 63. Overflow sets out_overflow and out_inexact. The result is infinity (exponent field 0x7FF, zero fraction) for modes 0 and 4, for mode 2 with a positive sign, and for mode 1 with a negative sign. In every other case the result is the largest finite magnitude (exponent field 0x7FE, all-ones fraction). The input sign is kept in both cases.
- R7: With flush-to-zero off, a negative exponent e shifts the significand right by -e. Every bit shifted out is ORed into bit 0. The exponent is then taken as 0, and rounding, including the mode 5 choice, uses the shifted value. out_underflow is set exactly when such a tiny value has nonzero rounding bits after the shift.
- R8: With flush-to-zero on, a negative exponent yields a zero of the input sign, with out_underflow set and out_inexact clear.
- R9: Apart from overflow and flush-to-zero, out_inexact is set exactly when the 10 rounding bits used are nonzero.
- R10: out_word holds the sign in bit 63, the exponent field in bits 62..52 and the 52 rounded fraction bits below the hidden bit in bits 51..0. A rounding carry out of the fraction raises the exponent field, so a tiny value that rounds up reaches exponent field 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 13 | Signed exponent, one below the packed biased exponent |
| in_sig | input | 64 | Significand: bit 62 hidden, bits 9..0 rounding bits |
| in_mode | input | 3 | Rounding mode code 0 to 5 |
| in_ftz | input | 1 | Flush tiny values to zero |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_word | output | 64 | Packed result |
| out_inexact | output | 1 | Inexact flag |
| out_overflow | output | 1 | Overflow flag |
| out_underflow | output | 1 | Underflow flag |

## Verification
The denormalizing shift and the mode-dependent increment meet in one cycle. The round-to-odd increment must be chosen from the bit that lands at position 10 after the shift, not from the original bit. A second meeting point is the rounding carry that lifts a tiny value to the smallest normal in the same cycle that underflow is flagged. Both cases are provoked by exponents from -1 down past -64, significands whose low bits sit at zero, at half and at all ones, and by sweeping every mode and both signs. A bench model that shifts one bit at a time with a sticky bit and picks the rounding direction by comparing the remainder with half judges each case.

// File: rtl/fprp_pkg.sv
package fprp_pkg;
  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_DOWN      = 3'd1,
    RM_UP        = 3'd2,
    RM_ZERO      = 3'd3,
    RM_NEAR_AWAY = 3'd4,
    RM_ODD       = 3'd5
  } rmode_e;
endpackage

// File: rtl/fprp_incr.sv
// Chooses the amount added below the result LSB before truncation.
module fprp_incr
  import fprp_pkg::*;
#(
  parameter int RND_W = 10
) (
  input  logic [2:0]       mode,
  input  logic             sign,
  input  logic             lsb,
  output logic [RND_W-1:0] inc
);
  localparam logic [RND_W-1:0] ALL_ONES = '1;
  localparam logic [RND_W-1:0] HALF     = RND_W'(1) << (RND_W - 1);

  always_comb begin
    case (mode)
      RM_NEAR_EVEN, RM_NEAR_AWAY: inc = HALF;
      RM_DOWN:                    inc = sign ? ALL_ONES : '0;
      RM_UP:                      inc = sign ? '0 : ALL_ONES;
      RM_ODD:                     inc = lsb ? '0 : ALL_ONES;
      default:                    inc = '0;
    endcase
  end
endmodule

// File: rtl/fprp_denorm.sv
// Right shift into subnormal range; every lost bit is ORed into bit 0.
module fprp_denorm #(
  parameter int SIG_W = 64,
  parameter int EXP_W = 13
) (
  input  logic signed [EXP_W-1:0] exp_in,
  input  logic [SIG_W-1:0]        sig_in,
  output logic [SIG_W-1:0]        sig_out
);
  logic [EXP_W-1:0] amt;
  logic             lost;

  always_comb begin
    amt = EXP_W'(-exp_in);
    if (exp_in >= 0) begin
      sig_out = sig_in;
      lost    = 1'b0;
    end else if (amt >= EXP_W'(SIG_W)) begin
      sig_out = '0;
      lost    = |sig_in;
    end else begin
      sig_out = sig_in >> amt;
      lost    = |(sig_in << (EXP_W'(SIG_W) - amt));
    end
    sig_out[0] = sig_out[0] | lost;
  end
endmodule

// File: rtl/fprp_round_pack.sv
module fprp_round_pack
  import fprp_pkg::*;
#(
  parameter int FRAC_W  = 52,
  parameter int FIELD_E = 11,
  parameter int RND_W   = 10,
  parameter int EXP_W   = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [FRAC_W+RND_W+1:0] in_sig,
  input  logic [2:0]              in_mode,
  input  logic                    in_ftz,
  output logic                    out_valid,
  output logic [FIELD_E+FRAC_W:0] out_word,
  output logic                    out_inexact,
  output logic                    out_overflow,
  output logic                    out_underflow
);
  localparam int SIG_W  = FRAC_W + RND_W + 2;
  localparam int WORD_W = FIELD_E + FRAC_W + 1;
  localparam int Q_W    = SIG_W - RND_W;
  localparam logic signed [EXP_W-1:0] EXP_TOP = EXP_W'((1 << FIELD_E) - 3);
  localparam logic [RND_W-1:0] HALF = RND_W'(1) << (RND_W - 1);

  logic [RND_W-1:0]  inc_norm, inc_tiny, inc_sel;
  logic [SIG_W-1:0]  sig_tiny, sig_sel, sum_norm, sum_sel;
  logic [RND_W-1:0]  rbits;
  logic [Q_W-1:0]    q;
  logic [WORD_W-1:0] body;
  logic [FIELD_E-1:0] exp_sel;
  logic              is_tiny, is_ovf, to_inf, tie_even;
  logic [WORD_W-1:0] word_d;
  logic              nx_d, of_d, uf_d;
  logic              unused_bits;

  // Increment for the value as given
  fprp_incr #(.RND_W(RND_W)) u_inc_norm (
    .mode(in_mode), .sign(in_sign), .lsb(in_sig[RND_W]), .inc(inc_norm)
  );

  fprp_denorm #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_denorm (
    .exp_in(in_exp), .sig_in(in_sig), .sig_out(sig_tiny)
  );

  // Increment again from the shifted significand (odd mode depends on it)
  fprp_incr #(.RND_W(RND_W)) u_inc_tiny (
    .mode(in_mode), .sign(in_sign), .lsb(sig_tiny[RND_W]), .inc(inc_tiny)
  );

  always_comb begin
    is_tiny  = in_exp < 0;
    sum_norm = in_sig + SIG_W'(inc_norm);
    is_ovf   = (in_exp >= EXP_TOP) && ((in_exp > EXP_TOP) || sum_norm[SIG_W-1]);
    to_inf   = (in_mode != RM_ODD) && (inc_norm != '0);

    sig_sel  = is_tiny ? sig_tiny : in_sig;
    inc_sel  = is_tiny ? inc_tiny : inc_norm;
    exp_sel  = is_tiny ? '0 : in_exp[FIELD_E-1:0];
    sum_sel  = sig_sel + SIG_W'(inc_sel);
    rbits    = sig_sel[RND_W-1:0];
    tie_even = (in_mode == RM_NEAR_EVEN) && (rbits == HALF);
    q        = sum_sel[SIG_W-1:RND_W];
    q[0]     = q[0] & ~tie_even;
    body     = {1'b0, exp_sel, {FRAC_W{1'b0}}} + {{(WORD_W-Q_W){1'b0}}, q};

    if (is_ovf) begin
      word_d = to_inf ? {in_sign, {FIELD_E{1'b1}}, {FRAC_W{1'b0}}}
                      : {in_sign, {(FIELD_E-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      nx_d = 1'b1;
      of_d = 1'b1;
      uf_d = 1'b0;
    end else if (is_tiny && in_ftz) begin
      word_d = {in_sign, {(WORD_W-1){1'b0}}};
      nx_d = 1'b0;
      of_d = 1'b0;
      uf_d = 1'b1;
    end else begin
      word_d = {in_sign, body[WORD_W-2:0]};
      nx_d = rbits != '0;
      of_d = 1'b0;
      uf_d = is_tiny && (rbits != '0);
    end
  end

  assign unused_bits = ^{body[WORD_W-1], sum_sel[RND_W-1:0], sum_norm[SIG_W-2:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_word      <= '0;
      out_inexact   <= 1'b0;
      out_overflow  <= 1'b0;
      out_underflow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word      <= word_d;
        out_inexact   <= nx_d;
        out_overflow  <= of_d;
        out_underflow <= uf_d;
      end
    end
  end
endmodule

// File: rtl/fprp_checker.sv
module fprp_checker #(
  parameter int EXP_W  = 13,
  parameter int SIG_W  = 64,
  parameter int WORD_W = 64
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_sign,
  input logic signed [EXP_W-1:0] in_exp,
  input logic [SIG_W-1:0]        in_sig,
  input logic [2:0]              in_mode,
  input logic                    in_ftz,
  input logic                    out_valid,
  input logic [WORD_W-1:0]       out_word,
  input logic                    out_inexact,
  input logic                    out_overflow,
  input logic                    out_underflow
);
  assert_legal_mode_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (in_mode <= 3'd5));

  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_no_overflow_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    out_overflow |-> (out_inexact && !out_underflow));

  assert_overflow_top_R6: assert property (@(posedge clk) disable iff (rst)
    out_overflow |-> (out_word[WORD_W-2:WORD_W-11] == 10'h3FF));

  assert_odd_lsb_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == 3'd5) |=> (!out_inexact || out_word[0]));

  assert_flush_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ftz && in_exp < 0)
      |=> (out_word[WORD_W-2:0] == '0 && out_underflow && !out_inexact));

  assert_tiny_range_R7: assert property (@(posedge clk) disable iff (rst)
    out_underflow |-> (out_word[WORD_W-2:WORD_W-11] == 10'h0));

  // Sign of the result always follows the input sign
  assert_sign_kept_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_word[WORD_W-1] == $past(in_sign)));
endmodule

bind fprp_round_pack fprp_checker #(
  .EXP_W(EXP_W), .SIG_W(SIG_W), .WORD_W(WORD_W)
) u_chk (.*);

// File: tb/fprp_round_pack_bench.sv
`timescale 1ns/1ps
module fprp_round_pack_bench;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic               in_sign = 1'b0;
  logic signed [12:0] in_exp = '0;
  logic [63:0]        in_sig = '0;
  logic [2:0]         in_mode = '0;
  logic               in_ftz = 1'b0;
  logic               out_valid;
  logic [63:0]        out_word;
  logic               out_inexact, out_overflow, out_underflow;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fprp_round_pack u_fprp_round_pack (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_sig(in_sig), .in_mode(in_mode), .in_ftz(in_ftz),
    .out_valid(out_valid), .out_word(out_word), .out_inexact(out_inexact),
    .out_overflow(out_overflow), .out_underflow(out_underflow)
  );

  // Reference: bitwise sticky shift, remainder compared against half.
  function automatic logic [66:0] model(input logic s, input int e,
                                        input logic [63:0] sig,
                                        input int md, input logic ftz);
    logic [63:0] v;
    logic [53:0] q;
    logic [9:0]  r;
    logic        up, tiny, inf;
    logic [65:0] total;
    if (e < 0 && ftz) return {s, 63'd0, 1'b0, 1'b0, 1'b1};
    v = sig;
    tiny = (e < 0);
    if (tiny) begin
      for (int i = 0; i < -e; i++) v = (v >> 1) | {63'd0, v[0]};
      e = 0;
    end
    q = v[63:10];
    r = v[9:0];
    case (md)
      0: up = (r > 10'h200) || (r == 10'h200 && q[0]);
      1: up = s && (r != 0);
      2: up = !s && (r != 0);
      4: up = (r >= 10'h200);
      5: up = (r != 0) && !q[0];
      default: up = 1'b0;
    endcase
    q = q + 54'(up);
    total = (66'(e) << 52) + 66'(q);
    if (!tiny && total >= (66'h7FF << 52)) begin
      inf = (md == 0) || (md == 4) || (md == 2 && !s) || (md == 1 && s);
      return {s, inf ? {11'h7FF, 52'd0} : {11'h7FE, {52{1'b1}}}, 1'b1, 1'b1, 1'b0};
    end
    return {s, total[62:0], r != 0, 1'b0, tiny && (r != 0)};
  endfunction

  task automatic run(input logic s, input int e, input logic [63:0] sig,
                     input int md, input logic ftz, input string tag);
    logic [66:0] exp_v;
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_exp = 13'(e); in_sig = sig;
    in_mode = 3'(md); in_ftz = ftz;
    exp_v = model(s, e, sig, md, ftz);
    @(negedge clk);
    in_valid = 1'b0;
    n_cmp++;
    if ({out_word, out_inexact, out_overflow, out_underflow} !== exp_v || out_valid !== 1'b1) begin
      n_bad++;
      $display("FAIL %s: e=%0d mode=%0d got %h/%b%b%b v=%b expected %h/%b%b%b",
               tag, e, md, out_word, out_inexact, out_overflow, out_underflow,
               out_valid, exp_v[66:3], exp_v[2], exp_v[1], exp_v[0]);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] one;
    void'($urandom(32'd4242));
    one = 64'h4000_0000_0000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0 || out_word !== 64'd0 || out_inexact || out_overflow || out_underflow) begin
      n_bad++;
      $display("FAIL R1 reset: got v=%b w=%h expected 0", out_valid, out_word);
    end
    rst = 1'b0;

    // R10 plain packing of 1.0
    run(0, 13'h3FE, one, 0, 0, "R10 exact one");
    // R2 valid drops one cycle after the strobe
    @(negedge clk);
    n_cmp++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL R2 idle: got %b expected 0", out_valid);
    end
    // R3 ties
    run(0, 100, one | 64'h200, 0, 0, "R3 tie even down");
    run(0, 100, one | 64'h600, 0, 0, "R3 tie even up");
    run(1, 100, one | 64'h200, 4, 0, "R3 tie away");
    // R4 directed modes, both signs
    for (int md = 1; md <= 3; md++) begin
      run(0, 500, one | 64'h1, md, 0, "R4 directed pos");
      run(1, 500, one | 64'h1, md, 0, "R4 directed neg");
    end
    // R5 odd
    run(0, 700, one, 5, 0, "R5 odd exact");
    run(0, 700, one | 64'h3, 5, 0, "R5 odd from even");
    run(1, 700, one | 64'h403, 5, 0, "R5 odd already odd");
    // R10 carry into exponent
    run(0, 13'h3FE, 64'h7FFF_FFFF_FFFF_FE00, 0, 0, "R10 carry");
    // R6 overflow in every mode, both signs
    for (int md = 0; md <= 5; md++) begin
      run(0, 13'h7FE, one, md, 0, "R6 overflow pos");
      run(1, 13'h7FE, one, md, 0, "R6 overflow neg");
      run(0, 13'h7FD, 64'h7FFF_FFFF_FFFF_FFFF, md, 0, "R6 edge carry");
    end
    // R7 subnormal shifts, R10 tiny rounding to min normal
    run(0, -1, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, "R7 R10 round to min normal");
    run(0, -1, one | 64'h400, 5, 0, "R7 odd after shift");
    run(1, -53, one, 2, 0, "R7 deep shift");
    run(0, -100, one, 5, 0, "R7 sticky only");
    run(0, -12, one, 3, 0, "R7 exact tiny");
    // R8 flush
    run(1, -5, one | 64'h3FF, 2, 1, "R8 flush neg");
    run(0, -1, one, 0, 1, "R8 flush pos");

    // Random mix, R9 inexact across all paths
    for (int k = 0; k < 4000; k++) begin
      logic [63:0] sg;
      int e, band;
      sg = {2'b01, 30'($urandom), $urandom};
      case ($urandom_range(0, 4))
        0: sg[9:0] = 10'h0;
        1: sg[9:0] = 10'h200;
        2: sg[9:0] = 10'h3FF;
        3: sg[61:10] = {52{1'b1}};
        default: ;
      endcase
      band = $urandom_range(0, 3);
      if (band == 0)      e = $urandom_range(1, 2044);
      else if (band == 1) e = $urandom_range(2044, 2047);
      else if (band == 2) e = -$urandom_range(1, 70);
      else                e = -$urandom_range(60, 200);
      run($urandom_range(0, 1), e, sg, $urandom_range(0, 5),
          ($urandom_range(0, 7) == 0), "R9 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule